// File: doc/BRIEF.md
# Row Chain Belief-Propagation Sweep Controller

This block is the address and command generator for a single processor in a stereo disparity engine that uses tree-structured belief propagation. Each image row is treated as a chain. A left-to-right pass produces one horizontal message per pixel and saves it. A right-to-left pass then produces the reverse horizontal message, the two vertical messages and, on the last iteration only, a disparity choice. The controller does none of the message arithmetic. It issues one operation at a time to an external message engine and waits for that engine's completion strobe. With each operation it supplies the column, the row, the iteration number, the read and write strobes for the row-length rightward store and the single-entry leftward register, and the bank bits for the vertical message store.

Rows are split into groups of `PROCS`. The processor with index `proc_id` handles row `group*PROCS + proc_id` of each group. The groups are visited in ascending order, and the whole set of groups is repeated for `ITERS` iterations. Vertical messages are read from the bank given by the parity of the current iteration and written to the other bank, so the values produced in one iteration are consumed in the next. On each disparity operation the engine presents the per-label totals (data cost plus all incoming messages), and the block returns the index of the smallest one.

Top module: `bp_row_sequencer`

## Requirements
- R1: After reset, `req_valid`, `busy`, `frame_done` and `disp_valid` are all low.
- R2: A one-cycle `start` while idle begins a frame in the next cycle. With no `start` nothing is requested. A `start` while `busy` is ignored and does not restart the ordering.
- R3: In the inward pass, op code 0 (rightward) is requested once for each column from 0 up to `COLS-1`. `rbuf_we` is high only in the cycle in which a rightward op is accepted (`req_valid` and `eng_done` both high).
- R4: In the outward pass, columns run from `COLS-1` down to 0. Each column gets op 1 (leftward), op 2 (downward) and op 3 (upward) in that order, followed by op 4 (decision) when the decision is due. `rbuf_re` is high on every outward op and low on inward ops.
- R5: `lreg_we` is high only in the cycle in which a leftward op is accepted. `lreg_re` is high on outward ops at every column except `COLS-1`.
- R6: `req_row` equals `group*PROCS + proc_id`, and the groups run from 0 upward, one inward and one outward pass each.
- R7: The sequence over all groups repeats `ITERS` times, with `req_iter` counting from 0. `vrd_bank` equals bit 0 of `req_iter`, and `vwr_bank` is its inverse.
- R8: Op 4 is requested only when `req_iter` equals `ITERS-1`, once per pixel.
- R9: One cycle after a decision op is accepted, `disp_valid` pulses for one cycle. `disp_label` then holds the index of the smallest `COST_W`-bit field of `cost_vec` (label i in bits i*COST_W and up), with ties going to the lower index.
- R10: While `req_valid` is high and `eng_done` is low, the op, column, row and iteration stay unchanged in the next cycle. The op advances only on `eng_done`, whatever the engine latency.
- R11: One cycle after the final op of the frame is accepted, `frame_done` pulses high for a single cycle and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a frame when idle |
| proc_id | input | PROC_W | Index of this processor within a group |
| eng_done | input | 1 | Engine completed the current op |
| cost_vec | input | LABELS*COST_W | Per-label totals for the decision op |
| req_valid | output | 1 | An op is being requested |
| req_op | output | 3 | 0 right, 1 left, 2 down, 3 up, 4 decide |
| req_col | output | COL_W | Column of the current pixel |
| req_row | output | ROW_W | Row handled by this processor |
| req_iter | output | IT_W | Current iteration |
| rbuf_we | output | 1 | Write the rightward store at `req_col` |
| rbuf_re | output | 1 | Read the rightward store at `req_col` |
| lreg_we | output | 1 | Load the leftward register |
| lreg_re | output | 1 | Use the leftward register |
| vrd_bank | output | 1 | Vertical store bank to read |
| vwr_bank | output | 1 | Vertical store bank to write |
| disp_valid | output | 1 | Disparity result valid pulse |
| disp_label | output | LBL_W | Chosen disparity label |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
The bench builds the block with 4 columns, 4 rows, 2 processors per group, 2 iterations and 4 labels of 6 bits. This gives two groups and two iterations in a 72-op frame, so the group wrap, the iteration wrap, the bank swap and the decision ops that appear only on the last iteration all occur within a short run. The frames use engine latencies of 0, 1 and 2 cycles and both processor indices. The cost patterns include a unique minimum, an all-equal tie and a two-way tie at the upper labels.

// File: rtl/bp_seq_pkg.sv
package bp_seq_pkg;

  typedef enum logic [2:0] {
    OP_RIGHT  = 3'd0,
    OP_LEFT   = 3'd1,
    OP_DOWN   = 3'd2,
    OP_UP     = 3'd3,
    OP_DECIDE = 3'd4
  } bp_op_e;

  // outward op slot to op code: slot 0 left, 1 down, 2 up, 3 decide
  function automatic bp_op_e slot_to_op(input logic [1:0] slot);
    return bp_op_e'({1'b0, slot} + 3'd1);
  endfunction

  // last valid slot of an outward pixel
  function automatic logic [1:0] last_slot(input logic with_decide);
    return with_decide ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/bp_pos_tracker.sv
module bp_pos_tracker #(
  parameter int COLS   = 4,
  parameter int GROUPS = 2,
  parameter int ITERS  = 2,
  parameter int COL_W  = 2,
  parameter int GRP_W  = 1,
  parameter int IT_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  output logic [COL_W-1:0] col,
  output logic [GRP_W-1:0] grp,
  output logic [IT_W-1:0]  iter,
  output logic             outward,
  output logic             last_iter,
  output logic             frame_end
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUPS - 1);
  localparam logic [IT_W-1:0]  IT_LAST  = IT_W'(ITERS - 1);

  logic row_end;

  assign last_iter = (iter == IT_LAST);
  assign row_end   = outward && (col == '0);
  assign frame_end = adv && row_end && (grp == GRP_LAST) && last_iter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0; grp <= '0; iter <= '0; outward <= 1'b0;
    end else if (clear) begin
      col <= '0; grp <= '0; iter <= '0; outward <= 1'b0;
    end else if (adv) begin
      if (!outward) begin
        if (col == COL_LAST) outward <= 1'b1;
        else                 col <= col + 1'b1;
      end else if (!row_end) begin
        col <= col - 1'b1;
      end else begin
        outward <= 1'b0;
        if (grp == GRP_LAST) begin
          grp  <= '0;
          iter <= last_iter ? '0 : iter + 1'b1;
        end else begin
          grp <= grp + 1'b1;
        end
      end
    end
  end

  a_r3_inward_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !clear && !outward && col != COL_LAST |=> col == $past(col) + 1'b1);

  a_r4_outward_descends: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !clear && outward && col != '0 |=> outward && col == $past(col) - 1'b1);

  a_r6_group_advances: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !clear && row_end && grp != GRP_LAST |=> grp == $past(grp) + 1'b1 && !outward);

endmodule

// File: rtl/bp_op_stepper.sv
module bp_op_stepper
  import bp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       accept,
  input  logic       outward,
  input  logic       last_iter,
  output bp_op_e     op,
  output logic       pixel_adv
);

  logic [1:0] slot;
  logic       pixel_last;

  assign pixel_last = !outward || (slot == last_slot(last_iter));
  assign pixel_adv  = accept && pixel_last;
  assign op         = outward ? slot_to_op(slot) : OP_RIGHT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slot <= '0;
    else if (clear)  slot <= '0;
    else if (accept) slot <= pixel_last ? 2'd0 : slot + 2'd1;
  end

  a_r8_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    outward && !last_iter |-> slot != 2'd3);

  a_r4_inward_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !outward |-> slot == 2'd0);

endmodule

// File: rtl/bp_argmin.sv
module bp_argmin #(
  parameter int LABELS = 4,
  parameter int COST_W = 6,
  parameter int LBL_W  = 2
) (
  input  logic [LABELS*COST_W-1:0] cost_vec,
  output logic [LBL_W-1:0]         best
);

  function automatic logic [LBL_W-1:0] pick_min(input logic [LABELS*COST_W-1:0] v);
    logic [COST_W-1:0] m;
    logic [LBL_W-1:0]  idx;
    m   = v[COST_W-1:0];
    idx = '0;
    for (int i = 1; i < LABELS; i++) begin
      if (v[i*COST_W +: COST_W] < m) begin
        m   = v[i*COST_W +: COST_W];
        idx = LBL_W'(i);
      end
    end
    return idx;
  endfunction

  assign best = pick_min(cost_vec);

  always_comb begin
    for (int i = 0; i < LABELS; i++) begin
      a_r9_minimum_chosen: assert (cost_vec[int'(best)*COST_W +: COST_W] <= cost_vec[i*COST_W +: COST_W]);
    end
  end

endmodule

// File: rtl/bp_row_sequencer.sv
module bp_row_sequencer
  import bp_seq_pkg::*;
#(
  parameter int COLS   = 4,
  parameter int ROWS   = 4,
  parameter int PROCS  = 2,
  parameter int ITERS  = 2,
  parameter int LABELS = 4,
  parameter int COST_W = 6,
  localparam int GROUPS = ROWS / PROCS,
  localparam int COL_W  = (COLS   > 1) ? $clog2(COLS)   : 1,
  localparam int ROW_W  = (ROWS   > 1) ? $clog2(ROWS)   : 1,
  localparam int PROC_W = (PROCS  > 1) ? $clog2(PROCS)  : 1,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int IT_W   = (ITERS  > 1) ? $clog2(ITERS)  : 1,
  localparam int LBL_W  = (LABELS > 1) ? $clog2(LABELS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [PROC_W-1:0]        proc_id,
  input  logic                     eng_done,
  input  logic [LABELS*COST_W-1:0] cost_vec,
  output logic                     req_valid,
  output logic [2:0]               req_op,
  output logic [COL_W-1:0]         req_col,
  output logic [ROW_W-1:0]         req_row,
  output logic [IT_W-1:0]          req_iter,
  output logic                     rbuf_we,
  output logic                     rbuf_re,
  output logic                     lreg_we,
  output logic                     lreg_re,
  output logic                     vrd_bank,
  output logic                     vwr_bank,
  output logic                     disp_valid,
  output logic [LBL_W-1:0]         disp_label,
  output logic                     busy,
  output logic                     frame_done
);

  logic             launch;
  logic             accept;
  logic             pixel_adv;
  logic             frame_end;
  logic             outward;
  logic             last_iter;
  logic [GRP_W-1:0] grp;
  bp_op_e           op;
  logic [LBL_W-1:0] best;

  assign launch    = start && !busy;
  assign accept    = busy && eng_done;
  assign req_valid = busy;
  assign req_op    = op;
  assign req_row   = ROW_W'(int'(grp) * PROCS + int'(proc_id));

  assign rbuf_we  = accept && (op == OP_RIGHT);
  assign rbuf_re  = busy && outward;
  assign lreg_we  = accept && (op == OP_LEFT);
  assign lreg_re  = busy && outward && (req_col != COL_W'(COLS - 1));
  assign vrd_bank = req_iter[0];
  assign vwr_bank = ~req_iter[0];

  bp_pos_tracker #(
    .COLS(COLS), .GROUPS(GROUPS), .ITERS(ITERS),
    .COL_W(COL_W), .GRP_W(GRP_W), .IT_W(IT_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .clear(launch), .adv(pixel_adv),
    .col(req_col), .grp(grp), .iter(req_iter), .outward(outward),
    .last_iter(last_iter), .frame_end(frame_end)
  );

  bp_op_stepper u_step (
    .clk(clk), .rst_n(rst_n), .clear(launch), .accept(accept),
    .outward(outward), .last_iter(last_iter), .op(op), .pixel_adv(pixel_adv)
  );

  bp_argmin #(.LABELS(LABELS), .COST_W(COST_W), .LBL_W(LBL_W)) u_min (
    .cost_vec(cost_vec), .best(best)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      frame_done <= 1'b0;
      disp_valid <= 1'b0;
      disp_label <= '0;
    end else begin
      frame_done <= frame_end;
      if (launch)         busy <= 1'b1;
      else if (frame_end) busy <= 1'b0;
      disp_valid <= accept && (op == OP_DECIDE);
      if (accept && (op == OP_DECIDE)) disp_label <= best;
    end
  end

  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !eng_done |=> req_valid && $stable(req_op) && $stable(req_col)
                               && $stable(req_row) && $stable(req_iter));

  a_r8_decide_final_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd4 |-> req_iter == IT_W'(ITERS - 1));

  a_r11_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy ##1 !frame_done);

  a_r9_disp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !(req_valid && eng_done && req_op == 3'd4) |=> !disp_valid);

endmodule

// File: tb/bp_row_sequencer_bench.sv
module bp_row_sequencer_bench;

  localparam int COLS = 4, ROWS = 4, PROCS = 2, ITERS = 2, LABELS = 4, COST_W = 6;
  localparam int GROUPS = ROWS / PROCS;
  localparam int MAXOPS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [0:0] proc_id = 1'b0;
  logic eng_done = 1'b0;
  logic [LABELS*COST_W-1:0] cost_vec = '0;
  logic req_valid, rbuf_we, rbuf_re, lreg_we, lreg_re, vrd_bank, vwr_bank;
  logic disp_valid, busy, frame_done;
  logic [2:0] req_op;
  logic [1:0] req_col, req_row, disp_label;
  logic [0:0] req_iter;

  always #5 clk = ~clk;

  bp_row_sequencer #(.COLS(COLS), .ROWS(ROWS), .PROCS(PROCS), .ITERS(ITERS),
                     .LABELS(LABELS), .COST_W(COST_W)) u_bp_row_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .proc_id(proc_id), .eng_done(eng_done),
    .cost_vec(cost_vec), .req_valid(req_valid), .req_op(req_op), .req_col(req_col),
    .req_row(req_row), .req_iter(req_iter), .rbuf_we(rbuf_we), .rbuf_re(rbuf_re),
    .lreg_we(lreg_we), .lreg_re(lreg_re), .vrd_bank(vrd_bank), .vwr_bank(vwr_bank),
    .disp_valid(disp_valid), .disp_label(disp_label), .busy(busy), .frame_done(frame_done)
  );

  int checks = 0, failures = 0;
  int exp_op[MAXOPS], exp_col[MAXOPS], exp_row[MAXOPS], exp_it[MAXOPS];
  int exp_n;
  int lat = 0, wait_cnt = 0, cost_mode = 0;
  int acc_idx, err_op, err_col, err_row, err_it, err_bank, err_r, err_l, err_disp, err_hold;
  int dec_cnt, disp_seen, frame_pulses;
  logic disp_pend = 1'b0;
  int disp_exp;
  logic hold_pend = 1'b0;
  int h_op, h_col, h_row, h_it;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [LABELS*COST_W-1:0] make_cost(input int col, input int row, input int mode);
    logic [LABELS*COST_W-1:0] v;
    v = '0;
    for (int l = 0; l < LABELS; l++) begin
      int c;
      if (mode == 0)      c = 10 + ((l * 3 + col + row) % 4) * 7;
      else if (mode == 1) c = 33;
      else                c = (l >= 2) ? 5 : 40 - l;
      v[l*COST_W +: COST_W] = COST_W'(c);
    end
    return v;
  endfunction

  // reference: scan from highest label down, keeping ties at the lower index
  function automatic int ref_min(input logic [LABELS*COST_W-1:0] v);
    int b;
    b = LABELS - 1;
    for (int l = LABELS - 2; l >= 0; l--)
      if (v[l*COST_W +: COST_W] <= v[b*COST_W +: COST_W]) b = l;
    return b;
  endfunction

  task automatic build_exp(input int pid);
    exp_n = 0;
    for (int it = 0; it < ITERS; it++)
      for (int g = 0; g < GROUPS; g++) begin
        for (int c = 0; c < COLS; c++) begin
          exp_op[exp_n] = 0; exp_col[exp_n] = c; exp_row[exp_n] = g * PROCS + pid; exp_it[exp_n] = it; exp_n++;
        end
        for (int c = COLS - 1; c >= 0; c--)
          for (int o = 1; o <= ((it == ITERS - 1) ? 4 : 3); o++) begin
            exp_op[exp_n] = o; exp_col[exp_n] = c; exp_row[exp_n] = g * PROCS + pid; exp_it[exp_n] = it; exp_n++;
          end
      end
  endtask

  // engine model and per-op monitor
  always @(negedge clk) begin
    if (disp_pend) begin
      disp_seen++;
      if (!disp_valid || int'(disp_label) != disp_exp) err_disp++;
      disp_pend = 1'b0;
    end else if (disp_valid) err_disp++;
    if (frame_done) frame_pulses++;
    if (hold_pend && req_valid) begin
      if (int'(req_op) != h_op || int'(req_col) != h_col || int'(req_row) != h_row || int'(req_iter) != h_it)
        err_hold++;
    end
    hold_pend = 1'b0;
    if (eng_done) wait_cnt = 0;
    else if (req_valid) wait_cnt++;
    cost_vec = make_cost(int'(req_col), int'(req_row), cost_mode);
    eng_done = req_valid && (wait_cnt >= lat);
    #1;
    if (eng_done) begin
      if (acc_idx < exp_n) begin
        if (int'(req_op)   != exp_op[acc_idx])  err_op++;
        if (int'(req_col)  != exp_col[acc_idx]) err_col++;
        if (int'(req_row)  != exp_row[acc_idx]) err_row++;
        if (int'(req_iter) != exp_it[acc_idx])  err_it++;
      end else err_op++;
      if (vrd_bank != req_iter[0] || vwr_bank != !req_iter[0]) err_bank++;
      if (rbuf_we != (req_op == 3'd0) || rbuf_re != (req_op != 3'd0)) err_r++;
      if (lreg_we != (req_op == 3'd1) ||
          lreg_re != (req_op != 3'd0 && int'(req_col) != COLS - 1)) err_l++;
      if (req_op == 3'd4) begin
        dec_cnt++;
        disp_pend = 1'b1;
        disp_exp = ref_min(cost_vec);
      end
      acc_idx++;
    end else if (req_valid) begin
      if (rbuf_we || lreg_we) begin err_r++; err_l++; end
      hold_pend = 1'b1;
      h_op = int'(req_op); h_col = int'(req_col); h_row = int'(req_row); h_it = int'(req_iter);
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req_valid && !busy && !frame_done && !disp_valid, "R1 reset outputs low",
        int'({req_valid, busy, frame_done, disp_valid}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!req_valid && !busy, "R2 no request without start", int'(req_valid), 0);
  endtask

  task automatic run_frame(input int pid, input int l, input int mode, input logic poke);
    int n;
    @(posedge clk);
    proc_id = 1'(pid); lat = l; cost_mode = mode;
    build_exp(pid);
    acc_idx = 0; err_op = 0; err_col = 0; err_row = 0; err_it = 0; err_bank = 0;
    err_r = 0; err_l = 0; err_disp = 0; err_hold = 0; dec_cnt = 0; disp_seen = 0; frame_pulses = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && req_valid, "R2 start launches frame", int'(busy), 1);
    if (poke) begin
      repeat (9) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (frame_pulses == 0 && n < 3000) begin @(negedge clk); n++; end
    chk(frame_pulses == 1, "R11 frame_done seen", frame_pulses, 1);
    chk(!busy, "R11 busy falls with frame_done", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(frame_pulses == 1, "R11 single frame_done pulse", frame_pulses, 1);
    chk(acc_idx == exp_n, "R2 op count (start while busy ignored)", acc_idx, exp_n);
    chk(err_op == 0, "R3 R4 op ordering", err_op, 0);
    chk(err_col == 0, "R4 column ordering", err_col, 0);
    chk(err_row == 0, "R6 row from group and proc_id", err_row, 0);
    chk(err_it == 0, "R7 iteration count", err_it, 0);
    chk(err_bank == 0, "R7 vertical bank parity", err_bank, 0);
    chk(err_r == 0, "R3 rightward store strobes", err_r, 0);
    chk(err_l == 0, "R5 leftward register strobes", err_l, 0);
    chk(dec_cnt == COLS * GROUPS, "R8 decisions on final iteration only", dec_cnt, COLS * GROUPS);
    chk(err_disp == 0 && disp_seen == COLS * GROUPS, "R9 disparity label and pulse", err_disp, 0);
    chk(err_hold == 0, "R10 request held until done", err_hold, 0);
    chk(!req_valid, "R2 idle after frame", int'(req_valid), 0);
  endtask

  initial begin
    #1_500_000;
    failures++;
    checks++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    run_frame(0, 0, 0, 1'b0);
    run_frame(1, 2, 1, 1'b1);
    run_frame(0, 1, 2, 1'b0);
    run_frame(1, 0, 0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule